// File: doc/BRIEF.md
# DAT0 Write-Busy Detector

This block sits in the SD clock domain of a host controller. It keeps a single flag saying whether the DAT lines are in use, either by a write data transfer or by a command whose response carries a busy indication. The flag rises on the command's end bit. It falls once the card has finished signalling busy on DAT0 for the last block, for the block at which a block-gap stop was requested, or for the busy-type command. Busy means the card holds DAT0 low. When busy can begin, a window of `WINDOW` SD clocks opens. If DAT0 stays high for the whole window, the card is taken to be not busy.

Each fall of the flag raises a transfer-complete status pulse, gated by a status enable. A matching interrupt pulse also needs the signal enable. A fall that ends a transfer early at a block gap also raises a block-gap pulse. The raw DAT0 level is passed out for debug.

The state machine has four states:

- `ST_IDLE`: the flag is low.
- `ST_XFER`: write data blocks are moving.
- `ST_WIN`: the not-busy window is counting.
- `ST_BUSY`: the card is holding DAT0 low.

Its transitions are:

- **start-busy-cmd** (IDLE→WIN): an end pulse with the busy qualifier.
- **start-write** (IDLE→XFER): an end pulse with the write qualifier.
- **block-crc** (XFER→WIN): a CRC-status-end pulse.
- **busy-seen** (WIN→BUSY): DAT0 is sampled low.
- **window-expired**: DAT0 is sampled high in the last window cycle. The state goes to IDLE if the block was final, otherwise to XFER.
- **busy-released**: DAT0 is sampled high while in BUSY. The state goes to IDLE if final, otherwise to XFER.

Top module: `sdw_busy_detect`

## Requirements
- R1: While reset is asserted and right after it, `dat_active`, `tc_stat`, `tc_irq` and `gap_evt` are all 0.
- R2: A `cmd_end` pulse sampled in idle with `cmd_busy`=1 or `cmd_write`=1 makes `dat_active` 1 from the next cycle. A `cmd_end` pulse with both qualifiers 0 leaves it 0. A `crc_done` pulse sampled in idle leaves it 0.
- R3: The window opens on the cycle after the busy-type end bit, or after a CRC-status-end pulse. If DAT0 is sampled high on all `WINDOW` (8) edges, `dat_active` falls right after the 8th edge.
- R4: A DAT0 low sample on any edge of the window, including the 8th, holds `dat_active` at 1. It falls right after the first edge that samples DAT0 high again.
- R5: A `crc_done` pulse with `crc_last`=0 and `gap_stop`=0 returns the block to transfer once busy has ended, and `dat_active` stays 1.
- R6: A `crc_done` pulse with `crc_last`=1 clears `dat_active` when busy is released or the window runs out.
- R7: A `crc_done` pulse with `gap_stop`=1 and `crc_last`=0 clears `dat_active` once that block's busy ends. `gap_evt` pulses together with `tc_stat`.
- R8: `tc_stat` is a one-cycle pulse in the first cycle that `dat_active` is 0 after a fall, but only if `stat_en` was 1. `tc_irq` pulses alongside it only if `sig_en` is also 1.
- R9: `dat0_level` equals the DAT0 input at all times.
- R10: A `cmd_end` pulse that arrives while `dat_active` is 1 is ignored and does not move the release cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SD clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat0 | input | 1 | DAT0 line level; low means busy |
| cmd_end | input | 1 | Pulse at a command's end bit |
| cmd_busy | input | 1 | Qualifier: the command has a busy-type response |
| cmd_write | input | 1 | Qualifier: the command starts a write transfer |
| crc_done | input | 1 | Pulse when a block's CRC-status token ends |
| crc_last | input | 1 | Qualifier: that block is the last one |
| gap_stop | input | 1 | Block-gap stop request (level) |
| stat_en | input | 1 | Status enable for the completion events |
| sig_en | input | 1 | Signal enable for the interrupt pulse |
| dat_active | output | 1 | DAT line in use |
| tc_stat | output | 1 | Transfer-complete status pulse |
| tc_irq | output | 1 | Transfer-complete interrupt pulse |
| gap_evt | output | 1 | Block-gap event pulse |
| dat0_level | output | 1 | Debug copy of DAT0 |

## Verification
A state register stuck in the wrong phase shows up at `dat_active` and at the timing of `tc_stat`, usually within one window. If a busy sample is missed, the fall comes exactly at the 8th window edge instead of after the release. If the final-block latch is lost, the flag falls when it should stay high, or never falls. The scoreboard fixes the exact cycle of every completion pulse, so an off-by-one in the window counter or in the event register shows on the first transfer that uses it.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WIN  = 2'd2,
        ST_BUSY = 2'd3
    } busy_state_e;
endpackage

// File: rtl/sdw_busy_window.sv
module sdw_busy_window #(
    parameter int WINDOW = 8,
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic             expired,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CNT_W'(WINDOW - 1));
    assign count   = cnt_q;
endmodule

// File: rtl/sdw_busy_events.sv
module sdw_busy_events (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic at_gap,
    input  logic stat_en,
    input  logic sig_en,
    output logic tc_stat,
    output logic tc_irq,
    output logic gap_evt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_stat <= 1'b0;
            tc_irq  <= 1'b0;
            gap_evt <= 1'b0;
        end else begin
            tc_stat <= fire && stat_en;
            tc_irq  <= fire && stat_en && sig_en;
            gap_evt <= fire && at_gap && stat_en;
        end
    end
endmodule

// File: rtl/sdw_busy_detect.sv
module sdw_busy_detect #(
    parameter int WINDOW = 8,
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dat0,
    input  logic cmd_end,
    input  logic cmd_busy,
    input  logic cmd_write,
    input  logic crc_done,
    input  logic crc_last,
    input  logic gap_stop,
    input  logic stat_en,
    input  logic sig_en,
    output logic dat_active,
    output logic tc_stat,
    output logic tc_irq,
    output logic gap_evt,
    output logic dat0_level
);
    import sdw_pkg::*;

    busy_state_e      state, state_nxt;
    logic             final_q, final_nxt;
    logic             gap_q, gap_nxt;
    logic             win_start, win_expired, release_now;
    logic [CNT_W-1:0] win_cnt;

    sdw_busy_window #(.WINDOW(WINDOW)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (win_start),
        .run     (state == ST_WIN),
        .expired (win_expired),
        .count   (win_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            final_q <= 1'b0;
            gap_q   <= 1'b0;
        end else begin
            state   <= state_nxt;
            final_q <= final_nxt;
            gap_q   <= gap_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt   = state;
        final_nxt   = final_q;
        gap_nxt     = gap_q;
        win_start   = 1'b0;
        release_now = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_end && cmd_busy) begin        // start-busy-cmd
                    state_nxt = ST_WIN;
                    win_start = 1'b1;
                    final_nxt = 1'b1;
                    gap_nxt   = 1'b0;
                end else if (cmd_end && cmd_write) begin  // start-write
                    state_nxt = ST_XFER;
                    final_nxt = 1'b0;
                    gap_nxt   = 1'b0;
                end
            end
            ST_XFER: begin
                if (crc_done) begin                   // block-crc
                    state_nxt = ST_WIN;
                    win_start = 1'b1;
                    final_nxt = crc_last || gap_stop;
                    gap_nxt   = gap_stop && !crc_last;
                end
            end
            ST_WIN: begin
                if (!dat0)                            // busy-seen
                    state_nxt = ST_BUSY;
                else if (win_expired)                 // window-expired
                    release_now = 1'b1;
            end
            ST_BUSY: begin
                if (dat0)                             // busy-released
                    release_now = 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (release_now)
            state_nxt = final_q ? ST_IDLE : ST_XFER;
    end

    // Output process
    sdw_busy_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (release_now && final_q),
        .at_gap  (gap_q),
        .stat_en (stat_en),
        .sig_en  (sig_en),
        .tc_stat (tc_stat),
        .tc_irq  (tc_irq),
        .gap_evt (gap_evt)
    );

    assign dat_active = (state != ST_IDLE);
    assign dat0_level = dat0;
endmodule

// File: rtl/sdw_busy_detect_chk.sv
module sdw_busy_detect_chk #(
    parameter int WINDOW = 8,
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dat0,
    input logic                 cmd_end,
    input logic                 cmd_busy,
    input logic                 stat_en,
    input logic                 sig_en,
    input logic                 dat_active,
    input logic                 tc_stat,
    input logic                 tc_irq,
    input logic                 gap_evt,
    input sdw_pkg::busy_state_e state,
    input logic [CNT_W-1:0]     win_cnt
);
    import sdw_pkg::*;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && cmd_busy && !dat_active) |=> dat_active);

    p_window_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && dat0 && win_cnt == CNT_W'(WINDOW - 1)) |=> (state == ST_IDLE || state == ST_XFER));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !dat0) |=> (state == ST_BUSY && dat_active));

    p_tc_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_stat |-> (!dat_active && $past(dat_active) && $past(stat_en)));

    p_fall_gives_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dat_active) && $past(stat_en)) |-> tc_stat);

    p_irq_needs_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> (tc_stat && $past(sig_en)));

    p_gap_with_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_evt |-> tc_stat);

    p_tc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_stat |=> !tc_stat);
endmodule

bind sdw_busy_detect sdw_busy_detect_chk #(.WINDOW(WINDOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dat0       (dat0),
    .cmd_end    (cmd_end),
    .cmd_busy   (cmd_busy),
    .stat_en    (stat_en),
    .sig_en     (sig_en),
    .dat_active (dat_active),
    .tc_stat    (tc_stat),
    .tc_irq     (tc_irq),
    .gap_evt    (gap_evt),
    .state      (state),
    .win_cnt    (win_cnt)
);

// File: tb/sdw_busy_detect_tb.sv
module sdw_busy_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dat0 = 1'b1, cmd_end = 1'b0, cmd_busy = 1'b0, cmd_write = 1'b0;
    logic crc_done = 1'b0, crc_last = 1'b0, gap_stop = 1'b0;
    logic stat_en = 1'b1, sig_en = 1'b1;
    logic dat_active, tc_stat, tc_irq, gap_evt, dat0_level;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    typedef struct {int c; logic s; logic i; logic g;} ev_t;
    ev_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdw_busy_detect u_dut (
        .clk(clk), .rst_n(rst_n), .dat0(dat0), .cmd_end(cmd_end),
        .cmd_busy(cmd_busy), .cmd_write(cmd_write), .crc_done(crc_done),
        .crc_last(crc_last), .gap_stop(gap_stop), .stat_en(stat_en),
        .sig_en(sig_en), .dat_active(dat_active), .tc_stat(tc_stat),
        .tc_irq(tc_irq), .gap_evt(gap_evt), .dat0_level(dat0_level)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(int c, logic s, logic i, logic g);
        ev_t e;
        e.c = c; e.s = s; e.i = i; e.g = g;
        q.push_back(e);
    endtask

    task automatic pulse_cmd(logic b, logic w, output int e);
        cmd_end = 1'b1; cmd_busy = b; cmd_write = w;
        @(negedge clk);
        cmd_end = 1'b0; cmd_busy = 1'b0; cmd_write = 1'b0;
        e = cyc;
    endtask

    task automatic pulse_crc(logic last, logic gap, output int f);
        crc_done = 1'b1; crc_last = last; gap_stop = gap;
        @(negedge clk);
        crc_done = 1'b0; crc_last = 1'b0; gap_stop = 1'b0;
        f = cyc;
    endtask

    // Monitor: compares each completion pulse with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && (tc_stat || tc_irq || gap_evt)) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected event cyc=%0d actual=%b%b%b expected=none",
                             cyc, tc_stat, tc_irq, gap_evt);
                end else begin
                    ev_t e;
                    e = q.pop_front();
                    if (e.c != cyc || e.s !== tc_stat || e.i !== tc_irq || e.g !== gap_evt) begin
                        errors++;
                        $display("FAIL R8 event actual=cyc%0d %b%b%b expected=cyc%0d %b%b%b",
                                 cyc, tc_stat, tc_irq, gap_evt, e.c, e.s, e.i, e.g);
                    end
                end
            end
        end
    end

    initial begin
        int e, f, g;
        repeat (3) @(negedge clk);
        chk("R1 dat_active in reset", dat_active, 1'b0);
        chk("R1 tc_stat in reset", tc_stat, 1'b0);
        chk("R1 tc_irq in reset", tc_irq, 1'b0);
        chk("R1 gap_evt in reset", gap_evt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        chk("R1 dat_active after reset", dat_active, 1'b0);

        // R2/R3: busy-type command, card never drives busy
        pulse_cmd(1'b1, 1'b0, e);
        chk("R2 flag set after end bit", dat_active, 1'b1);
        push(e + 8, 1'b1, 1'b1, 1'b0);
        wait_to(e + 7);
        chk("R3 flag held in window", dat_active, 1'b1);
        wait_to(e + 8);
        chk("R3 flag cleared after window", dat_active, 1'b0);
        repeat (3) @(negedge clk);

        // R4/R9/R10: busy starts on the last window edge
        pulse_cmd(1'b1, 1'b0, e);
        wait_to(e + 7);
        dat0 = 1'b0;
        wait_to(e + 8);
        chk("R4 busy on 8th edge holds flag", dat_active, 1'b1);
        chk("R9 level low", dat0_level, 1'b0);
        wait_to(e + 10);
        pulse_cmd(1'b1, 1'b0, f);   // R10: ignored while active
        wait_to(e + 14);
        chk("R4 flag held during busy", dat_active, 1'b1);
        push(e + 15, 1'b1, 1'b1, 1'b0);
        dat0 = 1'b1;
        wait_to(e + 15);
        chk("R4 flag cleared on release", dat_active, 1'b0);
        chk("R9 level high", dat0_level, 1'b1);
        repeat (12) @(negedge clk);
        chk("R10 no extra activity", dat_active, 1'b0);

        // R5/R6: two-block write, signal enable off
        sig_en = 1'b0;
        pulse_cmd(1'b0, 1'b1, e);
        chk("R2 write sets flag", dat_active, 1'b1);
        wait_to(e + 3);
        pulse_crc(1'b0, 1'b0, f);
        wait_to(f + 1);
        dat0 = 1'b0;
        wait_to(f + 5);
        dat0 = 1'b1;
        wait_to(f + 7);
        chk("R5 flag stays between blocks", dat_active, 1'b1);
        wait_to(f + 9);
        pulse_crc(1'b1, 1'b0, g);
        push(g + 8, 1'b1, 1'b0, 1'b0);
        wait_to(g + 7);
        chk("R6 flag held in last window", dat_active, 1'b1);
        wait_to(g + 8);
        chk("R6 flag cleared after last block", dat_active, 1'b0);
        sig_en = 1'b1;
        repeat (3) @(negedge clk);

        // R7: block-gap stop
        pulse_cmd(1'b0, 1'b1, e);
        wait_to(e + 2);
        pulse_crc(1'b0, 1'b1, f);
        dat0 = 1'b0;
        wait_to(f + 4);
        chk("R7 flag held during gap busy", dat_active, 1'b1);
        push(f + 5, 1'b1, 1'b1, 1'b1);
        dat0 = 1'b1;
        wait_to(f + 5);
        chk("R7 flag cleared at gap", dat_active, 1'b0);
        chk("R7 gap event", gap_evt, 1'b1);
        repeat (3) @(negedge clk);

        // R8: status enable off gives no events
        stat_en = 1'b0;
        pulse_cmd(1'b1, 1'b0, e);
        wait_to(e + 8);
        chk("R8 flag clears with status off", dat_active, 1'b0);
        chk("R8 no tc with status off", tc_stat, 1'b0);
        stat_en = 1'b1;
        repeat (3) @(negedge clk);

        // R2: unqualified command and idle CRC pulse ignored
        pulse_cmd(1'b0, 1'b0, e);
        chk("R2 plain command ignored", dat_active, 1'b0);
        pulse_crc(1'b1, 1'b0, f);
        chk("R2 idle crc ignored", dat_active, 1'b0);
        repeat (10) @(negedge clk);
        chk("R2 still idle", dat_active, 1'b0);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing events actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule